// File: doc/BRIEF.md
# Receive Link Fault Status Combiner

This block sits beside a four-channel serial receiver. It holds which channels are switched on, and it reduces each channel's monitor results to one link-fault flag per channel. Three digital monitor results arrive for each channel: signal amplitude, transition density and frequency range. Each one is 1 when that monitor sees a problem. A per-channel loopback select changes which monitors count. In loopback there is no line signal to measure, so the amplitude result is dropped.

The channel enables come from an 8-bit input through a level-transparent register. While the load strobe is high, the register follows the input on every clock. Once the strobe drops, the register holds the last value. A channel that is switched off always shows a fault. The fault flag is active low and registered: it reads 0 for a fault and 1 for a healthy link.

Top module: `rx_link_status`

## Requirements
- R1: After a clock edge with `rst_n` low, `ch_en` is 4'b0000 and `link_ok_n` is 4'b0000 (all channels disabled and faulted).
- R2: On every clock edge with `en_load` high, `ch_en[i]` takes the value of `en_in[2*i]` (channel 0 = bit 0, 1 = bit 2, 2 = bit 4, 3 = bit 6).
- R3: On a clock edge with `en_load` low, `ch_en` keeps its value, whatever `en_in` carries.
- R4: The odd bits `en_in[1]`, `en_in[3]`, `en_in[5]` and `en_in[7]` have no effect on `ch_en` or `link_ok_n`.
- R5: A channel whose `ch_en` bit is 0 shows `link_ok_n` = 0, whatever its monitor inputs are.
- R6: For an enabled channel with `loop_sel[i]` = 0, `link_ok_n[i]` is 0 exactly when at least one of `amp_bad[i]`, `dens_bad[i]` or `freq_bad[i]` is 1.
- R7: For an enabled channel with `loop_sel[i]` = 1, `amp_bad[i]` is ignored, and `link_ok_n[i]` is 0 exactly when `dens_bad[i]` or `freq_bad[i]` is 1.
- R8: Each channel's flag depends only on that channel's own enable, loopback and monitor bits.
- R9: `link_ok_n` is registered. It shows the `ch_en` and monitor values sampled at the previous clock edge, so an input change appears one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_in | input | 8 | Channel enable input; even bits are used, odd bits are spare |
| en_load | input | 1 | Load strobe: enable register follows `en_in` while high |
| loop_sel | input | 4 | Per-channel local loopback select |
| amp_bad | input | 4 | Per-channel amplitude monitor problem flag |
| dens_bad | input | 4 | Per-channel transition-density monitor problem flag |
| freq_bad | input | 4 | Per-channel frequency-range monitor problem flag |
| ch_en | output | 4 | Current enable state per channel |
| link_ok_n | output | 4 | Per-channel link status, 0 = fault, registered |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge. They also assume that the monitor flags are synchronous to `clk`, because the fault checks compare the inputs sampled at one edge with the flag at the next. The bench changes every input only on the falling edge and drops the strobe before it moves the monitor inputs. This keeps each vector inside those assumptions and lets each flag be predicted from one edge.

// File: rtl/rx_link_pkg.sv
// Package: shared sizes and the per-channel status rule.
// Assumes monitor flags are 1 for "problem" and the status output is active low.
package rx_link_pkg;

    localparam int unsigned NUM_CH_DEF = 4;
    localparam int unsigned EN_W_DEF   = 8;

    // Evaluate one channel: returns 1 for a healthy link, 0 for a fault.
    function automatic logic chan_ok(
        input logic en,
        input logic loop,
        input logic amp,
        input logic dens,
        input logic freq
    );
        logic amp_counts;
        amp_counts = amp & ~loop;
        return en & ~dens & ~freq & ~amp_counts;
    endfunction

endpackage

// File: rtl/rx_en_latch.sv
// Module: rx_en_latch
// Enable register with level-transparent load. While load is high, the
// register follows the selected bit of each channel's slice of en_in on
// every clock. While load is low, it holds. Channel i uses bit STRIDE*i;
// the other bits of each slice are spare. Assumes EN_W is a multiple of NUM_CH.
module rx_en_latch #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned EN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EN_W-1:0]   en_in,
    input  logic              load,
    output logic [NUM_CH-1:0] en_q
);
    localparam int unsigned STRIDE = EN_W / NUM_CH;

    logic [NUM_CH-1:0] en_pick;
    logic              unused_spare_bits;

    // Reduce all input bits so spare bits have a defined sink.
    assign unused_spare_bits = ^en_in;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_pick
            // Pick the active bit of this channel's slice.
            assign en_pick[i] = en_in[i*STRIDE];
        end
    endgenerate

    // Load while the strobe is high, hold otherwise; reset disables all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (load) begin
            en_q <= en_pick;
        end
    end

endmodule

// File: rtl/rx_fault_merge.sv
// Module: rx_fault_merge
// Combines the three monitor flags per channel with enable and loopback
// into a registered active-low status. Assumes flags are synchronous to clk.
module rx_fault_merge #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] loop,
    input  logic [NUM_CH-1:0] amp,
    input  logic [NUM_CH-1:0] dens,
    input  logic [NUM_CH-1:0] freq,
    output logic [NUM_CH-1:0] ok_n_q
);
    import rx_link_pkg::*;

    logic [NUM_CH-1:0] ok_d;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // Evaluate this channel's status from its own inputs only.
            assign ok_d[i] = chan_ok(en[i], loop[i], amp[i], dens[i], freq[i]);
        end
    endgenerate

    // Register the status; reset shows every channel faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_n_q <= '0;
        end else begin
            ok_n_q <= ok_d;
        end
    end

endmodule

// File: rtl/rx_link_status.sv
// Module: rx_link_status (top)
// Per-channel enable holding and link-fault reduction for a multi-channel
// serial receiver. Assumes all inputs are synchronous to clk.
module rx_link_status #(
    parameter int unsigned NUM_CH = rx_link_pkg::NUM_CH_DEF,
    parameter int unsigned EN_W   = rx_link_pkg::EN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EN_W-1:0]   en_in,
    input  logic              en_load,
    input  logic [NUM_CH-1:0] loop_sel,
    input  logic [NUM_CH-1:0] amp_bad,
    input  logic [NUM_CH-1:0] dens_bad,
    input  logic [NUM_CH-1:0] freq_bad,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] link_ok_n
);
    // Enable register with transparent load.
    rx_en_latch #(
        .NUM_CH (NUM_CH),
        .EN_W   (EN_W)
    ) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en_in (en_in),
        .load  (en_load),
        .en_q  (ch_en)
    );

    // Monitor reduction into the registered status.
    rx_fault_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ch_en),
        .loop   (loop_sel),
        .amp    (amp_bad),
        .dens   (dens_bad),
        .freq   (freq_bad),
        .ok_n_q (link_ok_n)
    );

endmodule

// File: rtl/rx_link_status_chk.sv
// Module: rx_link_status_chk
// Property checker bound to rx_link_status. Assumes inputs are stable at
// each rising edge.
module rx_link_status_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned EN_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EN_W-1:0]   en_in,
    input logic              en_load,
    input logic [NUM_CH-1:0] loop_sel,
    input logic [NUM_CH-1:0] amp_bad,
    input logic [NUM_CH-1:0] dens_bad,
    input logic [NUM_CH-1:0] freq_bad,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] link_ok_n
);
    localparam int unsigned STRIDE = EN_W / NUM_CH;

    // R3: without the strobe the enables hold.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_load |=> $stable(ch_en));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R2: with the strobe, channel i follows its mapped input bit.
            p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
                en_load |=> (ch_en[i] == $past(en_in[i*STRIDE])));
            // R5: a disabled channel reports a fault.
            p_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_en[i] |=> !link_ok_n[i]);
            // R6: any problem outside loopback faults the channel.
            p_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_en[i] && !loop_sel[i] && (amp_bad[i] || dens_bad[i] || freq_bad[i]))
                |=> !link_ok_n[i]);
            // R7: in loopback an amplitude problem alone leaves the link good.
            p_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_en[i] && loop_sel[i] && !dens_bad[i] && !freq_bad[i])
                |=> link_ok_n[i]);
        end
    endgenerate

endmodule

bind rx_link_status rx_link_status_chk #(
    .NUM_CH (NUM_CH),
    .EN_W   (EN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_in     (en_in),
    .en_load   (en_load),
    .loop_sel  (loop_sel),
    .amp_bad   (amp_bad),
    .dens_bad  (dens_bad),
    .freq_bad  (freq_bad),
    .ch_en     (ch_en),
    .link_ok_n (link_ok_n)
);

// File: tb/rx_link_status_test.sv
// Bench: vector table walk plus directed reset, hold and timing tests.
module rx_link_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] en_in = '0;
    logic       en_load = 1'b0;
    logic [3:0] loop_sel = '0;
    logic [3:0] amp_bad = '0;
    logic [3:0] dens_bad = '0;
    logic [3:0] freq_bad = '0;
    logic [3:0] ch_en;
    logic [3:0] link_ok_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_link_status uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_in),
        .en_load   (en_load),
        .loop_sel  (loop_sel),
        .amp_bad   (amp_bad),
        .dens_bad  (dens_bad),
        .freq_bad  (freq_bad),
        .ch_en     (ch_en),
        .link_ok_n (link_ok_n)
    );

    // Fields: en_in, loop, amp, dens, freq, expected ch_en, expected link_ok_n.
    localparam int NVEC = 11;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h55, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF},
        {8'h55, 4'h0, 4'h1, 4'h0, 4'h0, 4'hF, 4'hE},
        {8'h55, 4'h0, 4'h0, 4'h2, 4'h0, 4'hF, 4'hD},
        {8'h55, 4'h0, 4'h0, 4'h0, 4'h4, 4'hF, 4'hB},
        {8'h55, 4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'hF},
        {8'h55, 4'hF, 4'h0, 4'h8, 4'h0, 4'hF, 4'h7},
        {8'hAA, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
        {8'h11, 4'h0, 4'h0, 4'h0, 4'h0, 4'h5, 4'h5},
        {8'h44, 4'h0, 4'h2, 4'h0, 4'h0, 4'hA, 4'h8},
        {8'h55, 4'h5, 4'h3, 4'h0, 4'h0, 4'hF, 4'hD},
        {8'hFF, 4'h0, 4'h0, 4'h0, 4'h8, 4'hF, 4'h7}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ch_en after reset", ch_en, 4'h0);
        check("R1 link_ok_n after reset", link_ok_n, 4'h0);
        rst_n = 1'b1;

        // Vector walk: R2 R4 R5 R6 R7 R8.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            en_in   = VEC[v][31:24];
            en_load = 1'b1;
            @(negedge clk);
            en_load  = 1'b0;
            loop_sel = VEC[v][23:20];
            amp_bad  = VEC[v][19:16];
            dens_bad = VEC[v][15:12];
            freq_bad = VEC[v][11:8];
            @(negedge clk);
            check($sformatf("R2 R4 ch_en vector %0d", v), ch_en, VEC[v][7:4]);
            check($sformatf("R5 R6 R7 R8 link_ok_n vector %0d", v), link_ok_n, VEC[v][3:0]);
        end

        // R3: strobe low, input changes ignored.
        loop_sel = '0; amp_bad = '0; dens_bad = '0; freq_bad = '0;
        en_in = 8'h55; en_load = 1'b1;
        @(negedge clk);
        en_load = 1'b0; en_in = 8'h00;
        repeat (3) @(negedge clk);
        check("R3 hold with strobe low", ch_en, 4'hF);
        check("R3 status with held enables", link_ok_n, 4'hF);

        // R9: monitor change shows one clock later.
        dens_bad = 4'h4;
        #1;
        check("R9 status before edge", link_ok_n, 4'hF);
        @(negedge clk);
        check("R9 status after edge", link_ok_n, 4'hB);
        dens_bad = '0;

        // R4: odd bits alone under load disable everything.
        en_in = 8'hAA; en_load = 1'b1;
        @(negedge clk);
        en_load = 1'b0;
        @(negedge clk);
        check("R4 odd bits ignored", ch_en, 4'h0);

        // R1: reset mid-run clears a loaded state.
        en_in = 8'h55; en_load = 1'b1;
        @(negedge clk);
        en_load = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ch_en after mid-run reset", ch_en, 4'h0);
        check("R1 link_ok_n after mid-run reset", link_ok_n, 4'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule